// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Port

A full-duplex asynchronous serial port for a simple peripheral register bus. The transmitter sends characters of 5 to 9 data bits, least significant bit first, with a start bit, an optional parity slot and one stop bit. The receiver oversamples the line 16 times per bit, confirms the start bit at mid-bit and samples the data at each bit centre. A programmable divider of the peripheral clock sets the bit rate.

Besides plain operation the port can tag characters as addresses for a multi-drop bus, force and recognise line breaks, and switch the pins into three test channel modes: automatic echo, local loopback and remote loopback. The receiver reports parity, framing and overrun errors. One level interrupt is the OR of the status bits whose enable bits are set. Byte-wide request/strobe signals let a DMA controller feed the transmitter and drain the receiver.

Register map (word addresses): 0 control, 1 divider, 2 data (write: transmit, read: receive), 3 status (read; any write clears the three error bits), 4 interrupt enable.

Top module: `mdrop_uart`

## Requirements
- R1: Control bits [2:0] set the character length to code+5 data bits for codes 0 to 4; codes 5 to 7 give 9 bits. Reset value of the control register is 3 (8 bits, no parity, normal mode).
- R2: Control bits [5:3] select the parity slot: 0 none, 1 even, 2 odd, 3 always 0, 4 always 1, 5 multi-drop address tag.
- R3: One bit lasts 16*max(D,1) clock cycles, where D is the divider register (address 1, reset value 1).
- R4: A transmitted frame is a low start bit, the data bits LSB first, the parity slot if enabled, and one high stop bit; the line idles high.
- R5: The receiver accepts a start bit only if the line is still low at mid-bit; a received character appears in data read bits [8:0] and sets status bit 0, which a data read or a DMA acknowledge clears.
- R6: Status bit 2 flags a parity mismatch, bit 3 a low stop bit, bit 4 a character completed while bit 0 was still set; all three stay set until status is written.
- R7: Control bit 8 forces the transmit line low.
- R8: A frame whose data bits, parity slot and stop bit are all low is a break: status bit 5 sets, no character is delivered and no framing error is flagged, and bit 5 clears once the line returns high.
- R9: In multi-drop mode, transmit-data bit 9 is sent in the parity slot; a received slot value appears in data read bit 9 and status bit 6.
- R10: Channel mode 1 (control bits [7:6]) echoes the RX pin onto the TX pin while the receiver still receives.
- R11: Channel mode 2 holds the TX pin high, feeds the transmitter into the receiver and ignores the RX pin.
- R12: Channel mode 3 routes the RX pin to the TX pin and the receiver gets no character.
- R13: Status bit 1 is set while the transmit holding register is empty; irq is high exactly when some status bit [6:0] and the same bit of the enable register (address 4) are both set.
- R14: dma_tx_req equals status bit 1 and dma_tx_we loads dma_tx_data untagged; dma_rx_req equals status bit 0, dma_rx_data is the low byte of the received character and dma_rx_ack consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| irq | output | 1 | Level interrupt |
| dma_tx_req | output | 1 | Transmit holding register empty |
| dma_tx_we | input | 1 | DMA write strobe into the transmitter |
| dma_tx_data | input | 8 | DMA transmit byte |
| dma_rx_req | output | 1 | Received character waiting |
| dma_rx_ack | input | 1 | DMA has taken the received character |
| dma_rx_data | output | 8 | Low byte of the received character |

## Verification
The bench sweeps every character length against every parity choice in both directions, so a design that miscounts the last data bit or computes parity over unsent bits shows a wrong character or slot value. It drives a short low glitch, a frame with a low stop bit, an all-low break and two unread characters, where a design without mid-bit confirmation, break discrimination or overrun tracking would deliver garbage, flag a framing error or lose the overrun flag. In the three channel modes it watches the TX pin every cycle while driving RX, catching a loopback that leaks the transmitter onto the pin or a remote mode that still delivers characters. A divider of 3 is timed against the start-bit length to catch an off-by-one in the baud counter.

// File: rtl/mdrop_uart_pkg.sv
`timescale 1ns/1ps
package mdrop_uart_pkg;
   localparam int MAX_BITS = 9;
   localparam int NB_W     = 4;
   localparam int OSR      = 16;
   localparam int SUB_W    = $clog2(OSR);
   localparam int ST_W     = 7;

   localparam int ST_RXRDY = 0;
   localparam int ST_TXRDY = 1;
   localparam int ST_PERR  = 2;
   localparam int ST_FERR  = 3;
   localparam int ST_OVR   = 4;
   localparam int ST_BRK   = 5;
   localparam int ST_ADDR  = 6;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0, PAR_EVEN = 3'd1, PAR_ODD = 3'd2,
      PAR_ZERO = 3'd3, PAR_ONE = 3'd4, PAR_ADDR = 3'd5
   } par_e;

   typedef enum logic [1:0] {
      CH_NORMAL = 2'd0, CH_ECHO = 2'd1, CH_LOCAL = 2'd2, CH_REMOTE = 2'd3
   } chan_e;

   function automatic logic par_bit(input logic [MAX_BITS-1:0] d,
                                    input logic [NB_W-1:0] nb,
                                    input par_e mode, input logic tag);
      logic x;
      x = 1'b0;
      for (int i = 0; i < MAX_BITS; i++)
         if (i < int'(nb)) x = x ^ d[i];
      case (mode)
         PAR_EVEN: return x;
         PAR_ODD:  return ~x;
         PAR_ONE:  return 1'b1;
         PAR_ADDR: return tag;
         default:  return 1'b0;
      endcase
   endfunction

   function automatic logic par_on(input par_e mode);
      return mode inside {PAR_EVEN, PAR_ODD, PAR_ZERO, PAR_ONE, PAR_ADDR};
   endfunction
endpackage

// File: rtl/mdrop_uart_baud.sv
`timescale 1ns/1ps
module mdrop_uart_baud #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   nxt;

   assign nxt  = {1'b0, cnt} + 1'b1;
   assign tick = (nxt >= {1'b0, div});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= nxt[DIV_W-1:0];
   end
endmodule

// File: rtl/mdrop_uart_tx.sv
`timescale 1ns/1ps
module mdrop_uart_tx
   import mdrop_uart_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                req,
   input  logic [MAX_BITS-1:0] din,
   input  logic                din_tag,
   input  logic [NB_W-1:0]     nbits,
   input  par_e                pmode,
   output logic                take,
   output logic                line
);
   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;
   localparam logic [SUB_W-1:0] LAST = SUB_W'(OSR - 1);

   tst_e                st;
   logic [SUB_W-1:0]    sub;
   logic [NB_W-1:0]     idx, nb_q;
   logic [MAX_BITS-1:0] sh;
   logic                pb, pen;

   assign take = tick && (st == T_IDLE) && req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= T_IDLE; sub <= '0; idx <= '0; nb_q <= NB_W'(8);
         sh <= '0; pb <= 1'b0; pen <= 1'b0;
      end else if (tick) begin
         sub <= sub + 1'b1;
         case (st)
            T_IDLE: begin
               sub <= '0;
               if (req) begin
                  st   <= T_START;
                  sh   <= din;
                  pb   <= par_bit(din, nbits, pmode, din_tag);
                  nb_q <= nbits;
                  pen  <= par_on(pmode);
               end
            end
            T_START: if (sub == LAST) begin st <= T_DATA; idx <= '0; end
            T_DATA: if (sub == LAST) begin
               sh <= sh >> 1;
               if (idx == nb_q - 1'b1) st <= pen ? T_PAR : T_STOP;
               else                    idx <= idx + 1'b1;
            end
            T_PAR:  if (sub == LAST) st <= T_STOP;
            T_STOP: if (sub == LAST) st <= T_IDLE;
            default: st <= T_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         T_START: line = 1'b0;
         T_DATA:  line = sh[0];
         T_PAR:   line = pb;
         default: line = 1'b1;
      endcase
   end
endmodule

// File: rtl/mdrop_uart_rx.sv
`timescale 1ns/1ps
module mdrop_uart_rx
   import mdrop_uart_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                line,
   input  logic [NB_W-1:0]     nbits,
   input  par_e                pmode,
   output logic                done,
   output logic [MAX_BITS-1:0] data,
   output logic                tag,
   output logic                perr,
   output logic                ferr,
   output logic                brk
);
   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_BRK} rst_e;
   localparam logic [SUB_W-1:0] LAST = SUB_W'(OSR - 1);
   localparam logic [SUB_W-1:0] MID  = SUB_W'(OSR / 2 - 1);

   rst_e                st;
   logic [SUB_W-1:0]    sub;
   logic [NB_W-1:0]     idx, nb_q;
   logic [MAX_BITS-1:0] sh;
   logic                pbit, seen1;
   par_e                pm_q;

   assign brk = (st == R_BRK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= R_IDLE; sub <= '0; idx <= '0; nb_q <= NB_W'(8); sh <= '0;
         pbit <= 1'b0; seen1 <= 1'b0; pm_q <= PAR_NONE;
         done <= 1'b0; data <= '0; tag <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            sub <= sub + 1'b1;
            case (st)
               R_IDLE: begin
                  sub <= '0;
                  if (!line) st <= R_START;
               end
               R_START: if (sub == MID) begin
                  sub <= '0;
                  if (line) st <= R_IDLE;
                  else begin
                     st <= R_DATA; idx <= '0; sh <= '0; pbit <= 1'b0;
                     seen1 <= 1'b0; nb_q <= nbits; pm_q <= pmode;
                  end
               end
               R_DATA: if (sub == LAST) begin
                  sh[idx] <= line;
                  seen1   <= seen1 | line;
                  if (idx == nb_q - 1'b1) st <= par_on(pm_q) ? R_PAR : R_STOP;
                  else                    idx <= idx + 1'b1;
               end
               R_PAR: if (sub == LAST) begin
                  pbit  <= line;
                  seen1 <= seen1 | line;
                  st    <= R_STOP;
               end
               R_STOP: if (sub == LAST) begin
                  if (!line && !seen1) st <= R_BRK;
                  else begin
                     st   <= R_IDLE;
                     done <= 1'b1;
                     data <= sh;
                     tag  <= (pm_q == PAR_ADDR) && pbit;
                     ferr <= !line;
                     perr <= par_on(pm_q) && (pm_q != PAR_ADDR) &&
                             (pbit != par_bit(sh, nb_q, pm_q, 1'b0));
                  end
               end
               R_BRK: if (line) st <= R_IDLE;
               default: st <= R_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mdrop_uart.sv
`timescale 1ns/1ps
module mdrop_uart
   import mdrop_uart_pkg::*;
#(
   parameter int BUS_W       = 16,
   parameter int ADDR_W      = 3,
   parameter int DIV_W       = 12,
   parameter int DMA_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq,
   output logic              dma_tx_req,
   input  logic              dma_tx_we,
   input  logic [DMA_W-1:0]  dma_tx_data,
   output logic              dma_rx_req,
   input  logic              dma_rx_ack,
   output logic [DMA_W-1:0]  dma_rx_data
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_BAUD = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(4);

   if (BUS_W < MAX_BITS + 1 || BUS_W < DIV_W) begin : g_bad_bus
      $error("mdrop_uart: BUS_W too narrow");
   end
   if (DIV_W < 2 || DMA_W > MAX_BITS || ADDR_W < 3) begin : g_bad_width
      $error("mdrop_uart: DIV_W, DMA_W or ADDR_W out of range");
   end

   logic [2:0]          len_code;
   par_e                pmode;
   chan_e               chan;
   logic                brk_ctl;
   logic [DIV_W-1:0]    div_q;
   logic [ST_W-1:0]     ien, status;
   logic                hold_full, hold_tag, rxrdy, perr, ferr, ovr, rx_tag;
   logic [MAX_BITS-1:0] hold_d, rx_data;
   logic [NB_W-1:0]     nbits;
   logic                tick, tx_take, tx_line, tx_int, rx_src, rx_line;
   logic                rx_done, rx_tag_n, rx_perr, rx_ferr, brk_active;
   logic [MAX_BITS-1:0] rx_data_n;
   logic                cfg_wr, hold_wr, rd_clr, st_wr;

   assign nbits   = (len_code > 3'd4) ? NB_W'(MAX_BITS) : NB_W'(len_code) + NB_W'(5);
   assign cfg_wr  = bus_sel && bus_wr;
   assign hold_wr = (cfg_wr && bus_addr == A_DATA) || dma_tx_we;
   assign st_wr   = cfg_wr && bus_addr == A_STAT;
   assign rd_clr  = (bus_sel && !bus_wr && bus_addr == A_DATA) || dma_rx_ack;

   // channel routing between pins and the two engines
   assign tx_int = tx_line & ~brk_ctl;
   always_comb begin
      case (chan)
         CH_ECHO:   begin txd = rxd;  rx_src = rxd;    end
         CH_LOCAL:  begin txd = 1'b1; rx_src = tx_int; end
         CH_REMOTE: begin txd = rxd;  rx_src = 1'b1;   end
         default:   begin txd = tx_int; rx_src = rxd;  end
      endcase
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_line = rx_src;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= '1;
         else begin
            ff[0] <= rx_src;
            for (int i = 1; i < SYNC_STAGES; i++) ff[i] <= ff[i-1];
         end
      end
      assign rx_line = ff[SYNC_STAGES-1];
   end

   mdrop_uart_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

   mdrop_uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req(hold_full), .din(hold_d),
      .din_tag(hold_tag), .nbits(nbits), .pmode(pmode), .take(tx_take), .line(tx_line));

   mdrop_uart_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_line), .nbits(nbits),
      .pmode(pmode), .done(rx_done), .data(rx_data_n), .tag(rx_tag_n),
      .perr(rx_perr), .ferr(rx_ferr), .brk(brk_active));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_code <= 3'd3; pmode <= PAR_NONE; chan <= CH_NORMAL; brk_ctl <= 1'b0;
         div_q <= DIV_W'(1); ien <= '0;
         hold_full <= 1'b0; hold_d <= '0; hold_tag <= 1'b0;
         rxrdy <= 1'b0; rx_data <= '0; rx_tag <= 1'b0;
         perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
      end else begin
         if (cfg_wr && bus_addr == A_CTRL) begin
            len_code <= bus_wdata[2:0];
            pmode    <= par_e'(bus_wdata[5:3]);
            chan     <= chan_e'(bus_wdata[7:6]);
            brk_ctl  <= bus_wdata[8];
         end
         if (cfg_wr && bus_addr == A_BAUD) div_q <= bus_wdata[DIV_W-1:0];
         if (cfg_wr && bus_addr == A_IEN)  ien   <= bus_wdata[ST_W-1:0];
         if (hold_wr) begin
            hold_full <= 1'b1;
            hold_d    <= dma_tx_we ? MAX_BITS'(dma_tx_data) : bus_wdata[MAX_BITS-1:0];
            hold_tag  <= dma_tx_we ? 1'b0 : bus_wdata[MAX_BITS];
         end else if (tx_take) hold_full <= 1'b0;
         if (rd_clr) rxrdy <= 1'b0;
         if (st_wr) begin perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0; end
         if (rx_done) begin
            rxrdy   <= 1'b1;
            rx_data <= rx_data_n;
            rx_tag  <= rx_tag_n;
            if (rxrdy && !rd_clr) ovr <= 1'b1;
            if (rx_perr) perr <= 1'b1;
            if (rx_ferr) ferr <= 1'b1;
         end
      end
   end

   always_comb begin
      status           = '0;
      status[ST_RXRDY] = rxrdy;
      status[ST_TXRDY] = !hold_full;
      status[ST_PERR]  = perr;
      status[ST_FERR]  = ferr;
      status[ST_OVR]   = ovr;
      status[ST_BRK]   = brk_active;
      status[ST_ADDR]  = rx_tag;
   end

   assign irq         = |(status & ien);
   assign dma_tx_req  = status[ST_TXRDY];
   assign dma_rx_req  = status[ST_RXRDY];
   assign dma_rx_data = rx_data[DMA_W-1:0];

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = BUS_W'({brk_ctl, chan, pmode, len_code});
         A_BAUD:  bus_rdata = BUS_W'(div_q);
         A_DATA:  bus_rdata = BUS_W'({rx_tag, rx_data});
         A_STAT:  bus_rdata = BUS_W'(status);
         A_IEN:   bus_rdata = BUS_W'(ien);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdrop_uart_chk.sv
`timescale 1ns/1ps
module mdrop_uart_chk
   import mdrop_uart_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  txd,
   input logic  rxd,
   input chan_e chan,
   input logic  brk_ctl,
   input logic  rx_done,
   input logic  rxrdy,
   input logic  rd_clr,
   input logic  ovr,
   input logic  brk_active,
   input logic  hold_wr,
   input logic  hold_full
);
   assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_ctl && chan == CH_NORMAL) |-> !txd);
   assert_ready_after_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> rxrdy);
   assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rxrdy && !rd_clr) |=> ovr);
   assert_no_char_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_active |-> !rx_done);
   assert_echo_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_ECHO) |-> (txd == rxd));
   assert_local_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_LOCAL) |-> txd);
   assert_remote_pin_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (chan == CH_REMOTE) |-> (txd == rxd));
   assert_load_busy_R14: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> hold_full);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .rxd(rxd), .chan(chan), .brk_ctl(brk_ctl),
   .rx_done(rx_done), .rxrdy(rxrdy), .rd_clr(rd_clr), .ovr(ovr),
   .brk_active(brk_active), .hold_wr(hold_wr), .hold_full(hold_full));

// File: tb/tb_mdrop_uart.sv
`timescale 1ns/1ps
module tb_mdrop_uart;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 0, bus_wr = 0, rxd = 1, dma_tx_we = 0, dma_rx_ack = 0;
   logic [2:0] bus_addr = 0;
   logic [15:0] bus_wdata = 0, bus_rdata;
   logic [7:0] dma_tx_data = 0, dma_rx_data;
   logic txd, irq, dma_tx_req, dma_rx_req;
   int checks = 0, errors = 0, bdiv = 1;
   bit finished = 0;

   always #2 clk = ~clk;

   mdrop_uart dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
      .txd(txd), .irq(irq), .dma_tx_req(dma_tx_req), .dma_tx_we(dma_tx_we),
      .dma_tx_data(dma_tx_data), .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack),
      .dma_rx_data(dma_rx_data));

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", r, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'(a);
      #1 d = int'(bus_rdata);
      @(negedge clk); bus_sel = 0;
   endtask

   function automatic int expar(input int d, input int nb, input int pm, input int tg);
      int ones = 0;
      for (int i = 0; i < nb; i++) ones += (d >> i) & 1;
      case (pm)
         1: return ones % 2;
         2: return 1 - ones % 2;
         4: return 1;
         5: return tg;
         default: return 0;
      endcase
   endfunction

   task automatic send(input int d, input int nb, input int pm, input int tg,
                       input int stopv, input int flip);
      int bt = 16 * bdiv;
      rxd = 0; idle(bt);
      for (int i = 0; i < nb; i++) begin rxd = d[i]; idle(bt); end
      if (pm != 0) begin rxd = 1'(expar(d, nb, pm, tg) ^ flip); idle(bt); end
      rxd = stopv[0]; idle(bt);
      rxd = 1; idle(bt);
   endtask

   // returns data | parity<<9 | stop<<10 | seen<<11
   task automatic get_tx(input int nb, input int haspar, output int res);
      int n = 0, d = 0, pb = 0, stp, ok;
      while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
      ok = (txd === 1'b0);
      idle(8 * bdiv);
      for (int i = 0; i < nb; i++) begin idle(16 * bdiv); d |= int'(txd) << i; end
      if (haspar != 0) begin idle(16 * bdiv); pb = int'(txd); end
      idle(16 * bdiv); stp = int'(txd);
      idle(16 * bdiv);
      res = d | (pb << 9) | (stp << 10) | (ok << 11);
   endtask

   task automatic watch_pin(input int n, input int mode, output int bad);
      bad = 0;
      repeat (n) begin
         @(negedge clk); #1;
         if (mode == 0 && txd !== rxd) bad++;
         if (mode == 1 && txd !== 1'b1) bad++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v, s, d, res, bad, low;
      idle(5); rst_n = 1; idle(2);

      rd(3, s);   chk("R13 reset status", s, 32'h02);
      rd(0, v);   chk("R1 reset control", v, 3);
      rd(1, v);   chk("R3 reset divider", v, 1);
      chk("R4 reset line idle", int'(txd), 1);
      chk("R13 reset irq", int'(irq), 0);

      for (int nb = 5; nb <= 9; nb++)
         for (int pm = 0; pm <= 4; pm++) begin
            d = (nb * 37 + pm * 53 + 5) & ((1 << nb) - 1);
            wr(0, (nb - 5) | (pm << 3));
            wr(2, d);
            get_tx(nb, pm != 0, res);
            chk($sformatf("R1 R2 R4 tx len=%0d par=%0d", nb, pm), res,
                d | (expar(d, nb, pm, 0) << 9) | (1 << 10) | (1 << 11));
         end

      for (int nb = 5; nb <= 9; nb++)
         for (int pm = 0; pm <= 4; pm++) begin
            d = (nb * 91 + pm * 29 + 3) & ((1 << nb) - 1);
            if (d == 0) d = 1;
            wr(0, (nb - 5) | (pm << 3));
            send(d, nb, pm, 0, 1, 0);
            rd(3, s); rd(2, v);
            chk($sformatf("R1 R2 R5 rx len=%0d par=%0d", nb, pm),
                (v & 16'h3FF) | ((s & 16'h1D) << 12), d | (1 << 12));
            rd(3, s);
            chk("R5 read clears ready", s & 1, 0);
         end

      wr(0, 3);
      rxd = 0; idle(4); rxd = 1; idle(400);
      rd(3, s);  chk("R5 glitch ignored", s & 16'h09, 0);

      wr(0, 3 | (1 << 3));
      send(8'h5B, 8, 1, 0, 1, 1);
      rd(3, s);  chk("R6 parity error", s & 16'h1D, 16'h05);
      wr(3, 0); rd(3, s);  chk("R6 error cleared by write", s & 16'h1C, 0);
      rd(2, v);
      wr(0, 3);
      send(8'h55, 8, 0, 0, 0, 0);
      rd(3, s);  chk("R6 framing error", s & 16'h1D, 16'h09);
      wr(3, 0); rd(2, v);
      send(8'h11, 8, 0, 0, 1, 0);
      send(8'h22, 8, 0, 0, 1, 0);
      rd(3, s);  chk("R6 overrun", s & 16'h1D, 16'h11);
      rd(2, v);  chk("R6 overrun keeps newest", v, 16'h22);
      wr(3, 0);

      rxd = 0; idle(16 * 14);
      rd(3, s);  chk("R8 break detected", s & 16'h29, 16'h20);
      rxd = 1; idle(6);
      rd(3, s);  chk("R8 break clears on high", s & 16'h29, 0);

      wr(0, 3 | (1 << 8)); idle(5);
      chk("R7 break forces low", int'(txd), 0);
      wr(0, 3); idle(3);
      chk("R7 line released", int'(txd), 1);

      wr(0, 3 | (5 << 3));
      wr(2, 16'h3C | (1 << 9));
      get_tx(8, 1, res);  chk("R9 tx address tag", res, 16'h3C | 16'hE00);
      wr(2, 16'h3C);
      get_tx(8, 1, res);  chk("R9 tx data untagged", res, 16'h3C | 16'hC00);
      send(8'hA5, 8, 5, 1, 1, 0);
      rd(3, s); rd(2, v);
      chk("R9 rx address tag", v | ((s & 16'h40) << 4), 16'h2A5 | 16'h400);
      send(8'hA5, 8, 5, 0, 1, 0);
      rd(2, v);  chk("R9 rx data untagged", v, 16'h0A5);

      wr(0, 3 | (1 << 6));
      fork
         send(8'h6D, 8, 0, 0, 1, 0);
         watch_pin(16 * 11, 0, bad);
      join
      chk("R10 echo pin follows rx", bad, 0);
      rd(2, v);  chk("R10 echo receiver gets char", v, 16'h6D);

      wr(0, 3 | (3 << 6));
      fork
         send(8'h93, 8, 0, 0, 1, 0);
         watch_pin(16 * 11, 0, bad);
      join
      chk("R12 remote pin follows rx", bad, 0);
      rd(3, s);  chk("R12 remote no char", s & 16'h19, 0);

      wr(0, 3 | (2 << 6));
      rxd = 0;
      fork
         wr(2, 16'h5A);
         watch_pin(300, 1, low);
      join
      rd(3, s); rd(2, v);
      rxd = 1;
      chk("R11 local pin stays high", low, 0);
      chk("R11 local loop delivers", v | ((s & 16'h1D) << 12), 16'h5A | (1 << 12));
      idle(40);
      wr(0, 3);

      wr(4, 16'h01); idle(1);
      chk("R13 irq masked source idle", int'(irq), 0);
      send(8'h77, 8, 0, 0, 1, 0);
      chk("R13 irq on rx ready", int'(irq), 1);
      rd(2, v);
      chk("R13 irq drops after read", int'(irq), 0);
      wr(4, 16'h02); idle(1);
      chk("R13 irq on tx ready", int'(irq), 1);
      wr(4, 16'h08); idle(1);
      chk("R13 irq other bits masked", int'(irq), 0);
      send(8'h44, 8, 0, 0, 0, 0);
      chk("R13 irq on framing error", int'(irq), 1);
      wr(3, 0); idle(1);
      chk("R13 irq cleared with error", int'(irq), 0);
      rd(2, v); wr(4, 0);

      chk("R14 tx request when empty", int'(dma_tx_req), 1);
      @(negedge clk); dma_tx_we = 1; dma_tx_data = 8'hC3;
      @(negedge clk); dma_tx_we = 0;
      chk("R14 tx request drops on load", int'(dma_tx_req), 0);
      get_tx(8, 0, res);  chk("R14 dma byte sent", res, 16'hC3 | 16'hC00);
      send(8'h9E, 8, 0, 0, 1, 0);
      chk("R14 rx request", int'(dma_rx_req), 1);
      chk("R14 rx byte", int'(dma_rx_data), 16'h9E);
      @(negedge clk); dma_rx_ack = 1;
      @(negedge clk); dma_rx_ack = 0;
      chk("R14 ack consumes", int'(dma_rx_req), 0);

      wr(1, 3); bdiv = 3;
      wr(2, 16'h01);
      n_wait: begin
         int n = 0;
         while (txd !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
      end
      low = 0;
      while (txd === 1'b0 && low < 1000) begin @(negedge clk); low++; end
      chk("R3 start bit length div=3", low, 48);
      idle(16 * 3 * 11);
      send(8'hB4, 8, 0, 0, 1, 0);
      rd(2, v);  chk("R3 rx at div=3", v, 16'hB4);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule